// File: doc/BRIEF.md
# Timing Reference Mode Controller

This controller decides which clock reference a timing unit follows and what frequency control word goes to the numerically controlled oscillator. The mode is provisioned. In free running mode the word is a fixed nominal value. The tracking modes are externally timed, through timed, and line timed (a loop timed code behaves the same as line timed). In a tracking mode the live word from the phase detector passes straight through, as long as the selected reference is sound.

When the selected reference fails and no permitted substitute is valid, the controller goes to holdover. In holdover it drives a stored word. That word is the average of the last few accepted samples, captured only after the reference has been valid for a full qualification run. The same qualification run must be met again before the controller returns to tracking.

In line timed mode the line direction can be fixed East, fixed West, or Auto. Auto switches direction without reverting. A backup-enable bit decides whether a fixed direction may fail over to the other direction or to the external reference. Framing and line-code provisioning bits are registered and passed through to the reference interface.

Top module: `tref_mode_ctrl`

## Requirements
- R1: `prov_mode` codes are 0 free running, 1 externally timed, 2 through timed, 3 line timed and 4 loop timed (same behaviour as 3). Codes 5 to 7 act as free running. `state_o` reports 0 FREE, 1 TRACK and 2 HOLD. `sel_o` reports 0 local oscillator, 1 external, 2 East line and 3 West line.
- R2: A change of `prov_mode` takes effect at the next clock edge and clears qualification progress. A tracking code enters TRACK with a starting reference that depends on the mode: externally timed selects 1, through timed selects 2 (East), and line or loop timed selects 3 when `line_dir`=1 (West) and 2 otherwise. For `line_dir`, 0 is East, 1 is West, and 2 or 3 is Auto.
- R3: In TRACK, when the selected reference's ok flag is low and no fallback applies, the next clock enters HOLD. `holdover_o` goes to 1 and `sel_o` does not change.
- R4: In FREE, `sel_o`=0 and `freq_word`=NOMINAL whatever the reference flags and `freq_in` do. HOLD is never entered from FREE.
- R5: In TRACK, `freq_word` equals `freq_in` in the same cycle.
- R6: In HOLD, `freq_word` holds the stored word constant, whatever `freq_in` does.
- R7: The stored word resets to NOMINAL. It is updated to floor(sum of the last 2^AVG_LOG accepted samples / 2^AVG_LOG). The update happens on a valid TRACK cycle that follows QUAL_CYCLES consecutive valid cycles. A sample is accepted on every TRACK cycle in which the selected reference is ok.
- R8: HOLD returns to TRACK on the first valid cycle that follows QUAL_CYCLES consecutive valid cycles of the selected reference. Any invalid cycle restarts the count. `recovered_o` is high for exactly the first cycle back in TRACK.
- R9: In line or loop timed mode, when the selected line direction fails, the selection moves to the other direction at the next clock, provided Auto is set or `backup_en`=1 and the other direction is ok. The selection does not revert when the first direction recovers.
- R10: In line or loop timed mode with `backup_en`=1, if no other direction is usable, the selection falls back to external (1) when `ext_ok`=1. With `backup_en`=0 and a fixed direction, a failure leads to HOLD even when the other direction is ok.
- R11: `ref_esf_o` and `ref_b8zs_o` follow `prov_esf` and `prov_b8zs` with a delay of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prov_mode | input | 3 | Provisioned mode code |
| line_dir | input | 2 | Line direction: 0 East, 1 West, 2 or 3 Auto |
| backup_en | input | 1 | Allow fallback to another reference |
| prov_esf | input | 1 | Framing select for the external reference (1 extended superframe) |
| prov_b8zs | input | 1 | Line code select for the external reference (1 B8ZS, 0 AMI) |
| ext_ok | input | 1 | External reference integrity |
| east_ok | input | 1 | East line reference integrity |
| west_ok | input | 1 | West line reference integrity |
| freq_in | input | FW | Measured frequency word from the phase detector |
| state_o | output | 2 | Controller state |
| sel_o | output | 2 | Selected reference index |
| freq_word | output | FW | Frequency control word to the oscillator |
| holdover_o | output | 1 | High while in HOLD |
| recovered_o | output | 1 | One-cycle pulse on return from HOLD |
| ref_esf_o | output | 1 | Registered framing select |
| ref_b8zs_o | output | 1 | Registered line code select |

## Verification
The in-line properties are checked on every cycle. They cover these rules: FREE never leads to HOLD, and a failed reference in TRACK always leads to a state or selection change. The frequency word stays frozen across consecutive HOLD cycles. The recovery pulse is a single cycle that occurs only on a return from HOLD, and a qualification clear always drops the qualified status. Some behaviour only the bench scenarios can show, against a cycle model driven by seeded random stimulus and directed cases. That covers the exact averaged value that is captured, the cycle count before recovery, the Auto switch and its non-reverting behaviour, the backup and external fallback choices, and the starting selections.

// File: rtl/tref_pkg.sv
package tref_pkg;
   typedef enum logic [1:0] {
      ST_FREE  = 2'd0,
      ST_TRACK = 2'd1,
      ST_HOLD  = 2'd2
   } tref_state_e;

   localparam logic [2:0] MD_FREE = 3'd0;
   localparam logic [2:0] MD_EXT  = 3'd1;
   localparam logic [2:0] MD_THRU = 3'd2;
   localparam logic [2:0] MD_LINE = 3'd3;
   localparam logic [2:0] MD_LOOP = 3'd4;

   localparam logic [1:0] RF_LOCAL = 2'd0;
   localparam logic [1:0] RF_EXT   = 2'd1;
   localparam logic [1:0] RF_EAST  = 2'd2;
   localparam logic [1:0] RF_WEST  = 2'd3;
endpackage

// File: rtl/tref_qual.sv
module tref_qual #(
   parameter int QUAL_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ok,
   input  logic clr,
   output logic full
);
   localparam int QW = $clog2(QUAL_CYCLES + 1);
   localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES);

   logic [QW-1:0] qcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                qcnt <= '0;
      else if (clr || !ok)       qcnt <= '0;
      else if (qcnt != QMAX)     qcnt <= qcnt + 1'b1;
   end

   assign full = (qcnt == QMAX);

   // R2: a clear always removes qualified status on the next cycle
   a_r2_clear_drops_full: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !full);
endmodule

// File: rtl/tref_hist.sv
module tref_hist #(
   parameter int          FW      = 16,
   parameter int          AVG_LOG = 2,
   parameter logic [FW-1:0] NOMINAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          capture,
   input  logic [FW-1:0] sample,
   output logic [FW-1:0] hold_word
);
   localparam int DEPTH = 1 << AVG_LOG;
   localparam int SW    = FW + AVG_LOG;

   logic [FW-1:0] win [DEPTH];
   logic [SW-1:0] sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win[0] <= '0;
      else if (load)    win[0] <= sample;
   end

   for (genvar g = 1; g < DEPTH; g++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    win[g] <= '0;
         else if (load) win[g] <= win[g-1];
      end
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < DEPTH; i++) sum = sum + SW'(win[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_word <= NOMINAL;
      else if (capture) hold_word <= sum[SW-1:AVG_LOG];
   end
endmodule

// File: rtl/tref_mode_ctrl.sv
module tref_mode_ctrl
   import tref_pkg::*;
#(
   parameter int            FW          = 16,
   parameter int            AVG_LOG     = 2,
   parameter int            QUAL_CYCLES = 8,
   parameter logic [FW-1:0] NOMINAL     = 16'h8000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    prov_mode,
   input  logic [1:0]    line_dir,
   input  logic          backup_en,
   input  logic          prov_esf,
   input  logic          prov_b8zs,
   input  logic          ext_ok,
   input  logic          east_ok,
   input  logic          west_ok,
   input  logic [FW-1:0] freq_in,
   output logic [1:0]    state_o,
   output logic [1:0]    sel_o,
   output logic [FW-1:0] freq_word,
   output logic          holdover_o,
   output logic          recovered_o,
   output logic          ref_esf_o,
   output logic          ref_b8zs_o
);
   if (FW < 2) begin : g_bad_fw
      $error("FW too small");
   end
   if (QUAL_CYCLES < (1 << AVG_LOG)) begin : g_bad_qual
      $error("QUAL_CYCLES must cover the averaging window");
   end

   tref_state_e   state_q, state_d;
   logic [1:0]    sel_q, sel_d, alt;
   logic [2:0]    mode_q;
   logic [3:0]    ref_ok;
   logic          sel_ok, alt_ok, is_line, sel_line, mode_chg, rec_d;
   logic          qclr, qfull, load, capture;
   logic [FW-1:0] hold_word;

   assign ref_ok   = {west_ok, east_ok, ext_ok, 1'b1};
   assign sel_ok   = ref_ok[sel_q];
   assign alt      = (sel_q == RF_EAST) ? RF_WEST : RF_EAST;
   assign alt_ok   = ref_ok[alt];
   assign is_line  = (mode_q == MD_LINE) || (mode_q == MD_LOOP);
   assign sel_line = (sel_q == RF_EAST) || (sel_q == RF_WEST);
   assign mode_chg = (prov_mode != mode_q);

   always_comb begin
      state_d = state_q;
      sel_d   = sel_q;
      rec_d   = 1'b0;
      if (mode_chg) begin
         case (prov_mode)
            MD_EXT:           begin state_d = ST_TRACK; sel_d = RF_EXT;  end
            MD_THRU:          begin state_d = ST_TRACK; sel_d = RF_EAST; end
            MD_LINE, MD_LOOP: begin
               state_d = ST_TRACK;
               sel_d   = (line_dir == 2'd1) ? RF_WEST : RF_EAST;
            end
            default:          begin state_d = ST_FREE;  sel_d = RF_LOCAL; end
         endcase
      end else begin
         case (state_q)
            ST_TRACK: if (!sel_ok) begin
               if (is_line && sel_line && (line_dir[1] || backup_en) && alt_ok)
                  sel_d = alt;
               else if (is_line && backup_en && ext_ok && sel_q != RF_EXT)
                  sel_d = RF_EXT;
               else
                  state_d = ST_HOLD;
            end
            ST_HOLD: if (sel_ok && qfull) begin
               state_d = ST_TRACK;
               rec_d   = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_FREE;
         sel_q       <= RF_LOCAL;
         mode_q      <= MD_FREE;
         recovered_o <= 1'b0;
         ref_esf_o   <= 1'b0;
         ref_b8zs_o  <= 1'b0;
      end else begin
         state_q     <= state_d;
         sel_q       <= sel_d;
         mode_q      <= prov_mode;
         recovered_o <= rec_d;
         ref_esf_o   <= prov_esf;
         ref_b8zs_o  <= prov_b8zs;
      end
   end

   assign qclr    = mode_chg || (state_d != state_q) || (sel_d != sel_q);
   assign load    = !mode_chg && (state_q == ST_TRACK) && sel_ok;
   assign capture = load && qfull;

   tref_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk(clk), .rst_n(rst_n), .ok(sel_ok), .clr(qclr), .full(qfull)
   );

   tref_hist #(.FW(FW), .AVG_LOG(AVG_LOG), .NOMINAL(NOMINAL)) u_hist (
      .clk(clk), .rst_n(rst_n), .load(load), .capture(capture),
      .sample(freq_in), .hold_word(hold_word)
   );

   always_comb begin
      case (state_q)
         ST_TRACK: freq_word = freq_in;
         ST_HOLD:  freq_word = hold_word;
         default:  freq_word = NOMINAL;
      endcase
   end

   assign state_o    = state_q;
   assign sel_o      = sel_q;
   assign holdover_o = (state_q == ST_HOLD);

   // R4: free running never leads into holdover
   a_r4_free_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_FREE) |=> (state_o != ST_HOLD));
   // R3: a failed reference in tracking forces a state or selection change
   a_r3_fail_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_TRACK && !sel_ok && !mode_chg) |=>
      (state_o != ST_TRACK || sel_o != $past(sel_o)));
   // R6: the oscillator word is frozen across holdover cycles
   a_r6_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (holdover_o && !mode_chg) |=> (!holdover_o || $stable(freq_word)));
   // R8: recovery pulse only when arriving in tracking from holdover
   a_r8_recover_from_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recovered_o) |-> (state_o == ST_TRACK && $past(holdover_o)));
   // R8: recovery pulse lasts one cycle
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      recovered_o |=> !recovered_o);
endmodule

// File: tb/tref_mode_ctrl_test.sv
`timescale 1ns/1ps
module tref_mode_ctrl_test;
   localparam int FW = 16;
   localparam int AL = 2;
   localparam int QC = 8;
   localparam logic [FW-1:0] NOM = 16'h8000;

   logic clk = 0, rst_n = 0;
   logic [2:0] prov_mode = 0;
   logic [1:0] line_dir = 0;
   logic backup_en = 0, prov_esf = 0, prov_b8zs = 0;
   logic ext_ok = 0, east_ok = 0, west_ok = 0;
   logic [FW-1:0] freq_in = 0;
   logic [1:0] state_o, sel_o;
   logic [FW-1:0] freq_word;
   logic holdover_o, recovered_o, ref_esf_o, ref_b8zs_o;

   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   tref_mode_ctrl #(.FW(FW), .AVG_LOG(AL), .QUAL_CYCLES(QC), .NOMINAL(NOM)) uut (
      .clk(clk), .rst_n(rst_n), .prov_mode(prov_mode), .line_dir(line_dir),
      .backup_en(backup_en), .prov_esf(prov_esf), .prov_b8zs(prov_b8zs),
      .ext_ok(ext_ok), .east_ok(east_ok), .west_ok(west_ok), .freq_in(freq_in),
      .state_o(state_o), .sel_o(sel_o), .freq_word(freq_word),
      .holdover_o(holdover_o), .recovered_o(recovered_o),
      .ref_esf_o(ref_esf_o), .ref_b8zs_o(ref_b8zs_o));

   // cycle model built from the requirements
   logic [1:0] m_st, m_sel;
   logic [2:0] m_mode;
   int         m_q;
   logic [FW-1:0] m_win [4];
   logic [FW-1:0] m_hold;
   logic m_rec, m_esf, m_b8;

   function automatic logic rok(logic [1:0] s);
      case (s)
         2'd0: return 1'b1;
         2'd1: return ext_ok;
         2'd2: return east_ok;
         default: return west_ok;
      endcase
   endfunction

   function automatic logic [FW-1:0] win_avg();
      logic [FW+1:0] s = 0;
      for (int i = 0; i < 4; i++) s = s + {2'b00, m_win[i]};
      return s[FW+1:2];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_sel = 0; m_mode = 0; m_q = 0; m_hold = NOM;
         m_rec = 0; m_esf = 0; m_b8 = 0;
         for (int i = 0; i < 4; i++) m_win[i] = 0;
      end else begin
         automatic logic ok = rok(m_sel);
         automatic logic chg = (prov_mode != m_mode);
         automatic logic [1:0] nst = m_st, nsel = m_sel;
         automatic logic nrec = 0, ld, cp;
         automatic logic line = (m_mode == 3 || m_mode == 4);
         automatic logic [1:0] alt = (m_sel == 2) ? 2'd3 : 2'd2;
         if (chg) begin
            if (prov_mode == 1) begin nst = 1; nsel = 1; end
            else if (prov_mode == 2) begin nst = 1; nsel = 2; end
            else if (prov_mode == 3 || prov_mode == 4) begin
               nst = 1; nsel = (line_dir == 1) ? 2'd3 : 2'd2;
            end else begin nst = 0; nsel = 0; end
         end else if (m_st == 1 && !ok) begin
            if (line && m_sel >= 2 && (line_dir[1] || backup_en) && rok(alt)) nsel = alt;
            else if (line && backup_en && ext_ok && m_sel != 1) nsel = 1;
            else nst = 2;
         end else if (m_st == 2 && ok && m_q == QC) begin
            nst = 1; nrec = 1;
         end
         ld = !chg && m_st == 1 && ok;
         cp = ld && m_q == QC;
         if (cp) m_hold = win_avg();
         if (ld) begin
            for (int i = 3; i > 0; i--) m_win[i] = m_win[i-1];
            m_win[0] = freq_in;
         end
         if (chg || nst != m_st || nsel != m_sel || !ok) m_q = 0;
         else if (m_q < QC) m_q = m_q + 1;
         m_st = nst; m_sel = nsel; m_rec = nrec; m_mode = prov_mode;
         m_esf = prov_esf; m_b8 = prov_b8zs;
      end
   end

   task automatic chk(input logic c, input string tag, input int act, input int exp);
      tests++;
      if (!c) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      automatic logic [FW-1:0] ef = (m_st == 1) ? freq_in : (m_st == 2) ? m_hold : NOM;
      chk(state_o == m_st, "R3 state", state_o, m_st);
      chk(sel_o == m_sel, "R9 selection", sel_o, m_sel);
      chk(holdover_o == (m_st == 2), "R3 holdover flag", holdover_o, m_st == 2);
      chk(recovered_o == m_rec, "R8 recovery pulse", recovered_o, m_rec);
      chk(ref_esf_o == m_esf && ref_b8zs_o == m_b8, "R11 config",
          {ref_esf_o, ref_b8zs_o}, {m_esf, m_b8});
      if (m_st == 0)      chk(freq_word == ef, "R4 nominal word", freq_word, ef);
      else if (m_st == 1) chk(freq_word == ef, "R5 live word", freq_word, ef);
      else                chk(freq_word == ef, "R7 stored word", freq_word, ef);
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         cmp_all();
         freq_in = 16'h7F00 + 16'($urandom_range(0, 511));
      end
   endtask

   initial begin
      #(200000 * 5);
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      automatic logic [FW-1:0] frz;
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(state_o == 0 && sel_o == 0, "R1 reset state", {state_o, sel_o}, 0);
      chk(freq_word == NOM && !holdover_o, "R4 reset word", freq_word, NOM);

      // R4 free running ignores references
      for (int k = 0; k < 12; k++) begin
         {ext_ok, east_ok, west_ok} = 3'($urandom());
         freq_in = 16'($urandom());
         @(negedge clk);
         chk(freq_word == NOM && sel_o == 0 && !holdover_o, "R4 free ignores inputs",
             freq_word, NOM);
      end

      // R2 external mode entry
      ext_ok = 1; east_ok = 1; west_ok = 1;
      prov_mode = 1;
      step(1);
      chk(state_o == 1 && sel_o == 1, "R2 ext entry", {state_o, sel_o}, 4'b0101);
      step(20);
      // R3 failure into holdover
      ext_ok = 0;
      step(1);
      chk(holdover_o == 1 && sel_o == 1, "R3 enter hold", {holdover_o, sel_o}, 3'b101);
      frz = freq_word;
      step(5);
      chk(freq_word == frz, "R6 hold word frozen", freq_word, frz);
      // R8 recovery after a broken then full qualification run
      ext_ok = 1; step(4); ext_ok = 0; step(1); ext_ok = 1;
      step(QC);
      chk(holdover_o == 1, "R8 not yet recovered", holdover_o, 1);
      step(1);
      chk(state_o == 1 && recovered_o == 1, "R8 recovered", {state_o, recovered_o}, 3'b011);
      step(1);
      chk(recovered_o == 0, "R8 pulse ends", recovered_o, 0);

      // R9 Auto switch, non-revertive
      prov_mode = 3; line_dir = 2; backup_en = 0;
      step(3);
      chk(sel_o == 2, "R2 line auto starts east", sel_o, 2);
      east_ok = 0; step(1);
      chk(sel_o == 3 && state_o == 1, "R9 auto to west", sel_o, 3);
      east_ok = 1; step(4);
      chk(sel_o == 3, "R9 non-revertive", sel_o, 3);

      // R10 fixed east, no backup: hold despite west valid
      prov_mode = 2; step(1);
      chk(sel_o == 2, "R2 thru selects east", sel_o, 2);
      prov_mode = 4; line_dir = 0; step(2);
      east_ok = 0; west_ok = 1; step(1);
      chk(holdover_o == 1 && sel_o == 2, "R10 no backup holds", {holdover_o, sel_o}, 3'b110);

      // R10 backup to external when west down
      east_ok = 1; prov_mode = 3; backup_en = 1; step(3);
      west_ok = 0; ext_ok = 1; east_ok = 0; step(1);
      chk(sel_o == 1 && state_o == 1, "R10 backup to external", sel_o, 1);

      // R2 west start, R1 unused code
      east_ok = 1; west_ok = 1; prov_mode = 0; step(1);
      line_dir = 1; prov_mode = 3; step(1);
      chk(sel_o == 3, "R2 west start", sel_o, 3);
      prov_mode = 6; step(1);
      chk(state_o == 0 && sel_o == 0, "R1 unused code is free", state_o, 0);

      // R11 config pass-through
      prov_esf = 1; prov_b8zs = 0; step(1);
      chk(ref_esf_o == 1 && ref_b8zs_o == 0, "R11 config follows", {ref_esf_o, ref_b8zs_o}, 2);

      // random mix
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 99) < 2) prov_mode = 3'($urandom_range(0, 6));
         if ($urandom_range(0, 99) < 3) line_dir = 2'($urandom());
         if ($urandom_range(0, 99) < 3) backup_en = ~backup_en;
         if ($urandom_range(0, 99) < 4) ext_ok = ~ext_ok;
         if ($urandom_range(0, 99) < 4) east_ok = ~east_ok;
         if ($urandom_range(0, 99) < 4) west_ok = ~west_ok;
         if ($urandom_range(0, 99) < 2) prov_esf = ~prov_esf;
         if ($urandom_range(0, 99) < 2) prov_b8zs = ~prov_b8zs;
         step(1);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule